// File: doc/BRIEF.md
# Multi-Lane Serial Audio Deserializer

This block turns serial audio data into parallel sample words. Up to four data lines carry audio at the same time. They share one bit clock and one word-select line, which are generated elsewhere. The clock logic around the block supplies a one-cycle strobe for each bit-sampling edge and marks the first bit of every frame. On each marked edge the block takes one bit from every lane. It counts bit positions inside each half-frame and shifts a 16-bit window of bits into a per-lane, per-channel register.

A frame ends when the next frame begins. At that point the finished frame's samples are copied into a holding stage and sent out on one parallel output, one word per cycle. Each word carries a lane number and a channel flag. The frame's configuration decides which samples are sent. Only the selected lanes are sent. A mono frame sends only its left sample. A filter mode can drop any lane whose first frame bit (its valid flag) has the wrong value.

The configuration covers bit order, active lane count, window start, filter mode and mono/stereo. It is taken when a frame starts and applies to that whole frame, both to capture and to output. All inputs are assumed to be already synchronous to `clk`.

Top module: `audio_lane_capture`

## Requirements
- R1: While reset is held, `out_valid` is low. The first frame after reset only starts a capture, so no word is sent until a second frame start closes it.
- R2: With `cfg_lsb_first` = 0, the first bit captured in the window lands in `out_data[15]`, and later bits fill toward bit 0.
- R3: With `cfg_lsb_first` = 1, the first bit captured in the window lands in `out_data[0]`, and later bits fill toward bit 15.
- R4: Bits are counted from 0 at the first sampling edge of each half-frame. Exactly the bits at positions `cfg_pos` through `cfg_pos`+15 form the sample. Bits outside the window, and line values when `samp_en` is low, have no effect on the output.
- R5: `cfg_lanes` selects the active lanes: 0 = lane 0, 1 = lanes 0-1, 2 = lanes 0-2, 3 = lanes 0-3. No word is ever sent for a lane above that count.
- R6: Filter modes 0 and 1 pass every active lane's sample in every frame.
- R7: A lane's valid flag is its bit at frame position 0. Mode 2 passes a lane only if that flag is 0. Mode 3 passes a lane only if that flag is 1. A dropped sample sends no word and does not shift the remaining words.
- R8: The left half is the part of the frame where `ws` keeps the level it had at the frame start, and its words have `out_chan` = 0. In stereo (`cfg_stereo` = 1), the other half gives words with `out_chan` = 1. In mono, only left words are sent.
- R9: The words of a finished frame go out on consecutive cycles. The first word appears two clock edges after the closing frame start is sampled (one edge to load, one to register). Words are ordered by ascending lane, with left before right within a lane.
- R10: The configuration inputs are latched at the frame start. Changing them during a frame does not change how that frame is captured or sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | One-cycle strobe marking a bit-sampling edge |
| frame_start | input | 1 | Marks the sampling edge that holds bit 0 of a frame; honoured only with `samp_en` |
| ws | input | 1 | Synchronized word-select level |
| sd | input | LANES | Synchronized serial data, one bit per lane |
| cfg_lsb_first | input | 1 | 0 = first bit is MSB, 1 = first bit is LSB |
| cfg_lanes | input | LANE_W | Highest active lane number |
| cfg_pos | input | POS_W | Bit position where the sample window starts in each half |
| cfg_mode | input | 2 | Valid-flag filter mode |
| cfg_stereo | input | 1 | 1 = capture both halves, 0 = left only |
| out_valid | output | 1 | A sample word is present this cycle |
| out_data | output | SAMPLE_W | Sample word |
| out_lane | output | LANE_W | Lane that the word came from |
| out_chan | output | 1 | 0 = left, 1 = right |

## Verification
The frame-start edge does three jobs in the same clock cycle. It hands the finished frame to the output stage, it samples bit 0 of the new frame (the valid flag, and with a window start of 0 also the first sample bit), and it latches a new configuration. The bench provokes this overlap in two ways. One test runs with a window start of 0, so the first sample bit falls on the frame-start edge. Another test changes every configuration input a few bits into a frame. In both cases the emitted words are compared against the configuration that was in force when each frame started. Lane filtering with mixed valid flags also produces gaps in the slot list. The bench judges these by checking that the remaining words still come out on back-to-back cycles.

// File: rtl/alc_pkg.sv
package alc_pkg;

   typedef enum logic [1:0] {
      CAP_EVERY  = 2'b00,
      CAP_RSVD   = 2'b01,
      CAP_IF_CLR = 2'b10,
      CAP_IF_SET = 2'b11
   } cap_mode_e;

   // Decide whether a lane's sample survives the valid-flag filter.
   function automatic logic mode_accepts(cap_mode_e mode, logic vflag);
      case (mode)
         CAP_IF_CLR: return !vflag;
         CAP_IF_SET: return vflag;
         default:    return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/alc_frame_track.sv
module alc_frame_track #(
   parameter int SAMPLE_W = 16,
   parameter int POS_W    = 5,
   parameter int CNT_W    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_en,
   input  logic             frame_start,
   input  logic             ws,
   input  logic [POS_W-1:0] pos,
   input  logic             stereo,
   output logic             fs,
   output logic             cap_en,
   output logic             cap_chan
);

   localparam int              CMP_W   = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if ((2 ** CNT_W) < (2 ** POS_W) + SAMPLE_W) begin : g_bad_cnt
      $error("alc_frame_track: CNT_W too small for window end");
   end

   logic             ws_ref_q;
   logic             chan_q;
   logic [CNT_W-1:0] cnt_q;
   logic             chan;
   logic [CNT_W-1:0] idx;
   logic [CMP_W-1:0] idx_x, lo, hi;

   always_comb begin
      fs       = samp_en & frame_start;
      chan     = fs ? 1'b0 : (ws != ws_ref_q);
      idx      = (fs || (chan != chan_q)) ? '0 : cnt_q;
      idx_x    = CMP_W'(idx);
      lo       = CMP_W'(pos);
      hi       = lo + CMP_W'(SAMPLE_W);
      cap_en   = samp_en && (idx_x >= lo) && (idx_x < hi) && (!chan || stereo);
      cap_chan = chan;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_ref_q <= 1'b0;
         chan_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (samp_en) begin
         if (fs) ws_ref_q <= ws;
         chan_q <= chan;
         cnt_q  <= (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
      end
   end

endmodule

// File: rtl/alc_lane_shift.sv
module alc_lane_shift #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic                cap_chan,
   input  logic                lsb_first,
   input  logic                fs,
   input  logic                sd_bit,
   output logic [SAMPLE_W-1:0] left_q,
   output logic [SAMPLE_W-1:0] right_q,
   output logic                vflag_q
);

   if (SAMPLE_W < 2) begin : g_bad_w
      $error("alc_lane_shift: SAMPLE_W must be at least 2");
   end

   logic [SAMPLE_W-1:0] tgt, shifted;

   always_comb begin
      tgt     = cap_chan ? right_q : left_q;
      shifted = lsb_first ? {sd_bit, tgt[SAMPLE_W-1:1]}
                          : {tgt[SAMPLE_W-2:0], sd_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         right_q <= '0;
         vflag_q <= 1'b0;
      end else begin
         if (cap_en && !cap_chan) left_q  <= shifted;
         if (cap_en &&  cap_chan) right_q <= shifted;
         if (fs)                  vflag_q <= sd_bit;
      end
   end

endmodule

// File: rtl/alc_emit.sv
module alc_emit #(
   parameter  int LANES    = 4,
   parameter  int SAMPLE_W = 16,
   localparam int SLOTS    = 2 * LANES,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int LANE_W   = SLOT_W - 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic [SLOTS-1:0]                load_mask,
   input  logic [SLOTS-1:0][SAMPLE_W-1:0]  load_data,
   output logic                            out_valid,
   output logic [SAMPLE_W-1:0]             out_data,
   output logic [LANE_W-1:0]               out_lane,
   output logic                            out_chan
);

   logic [SLOTS-1:0]               pend_q;
   logic [SLOTS-1:0][SAMPLE_W-1:0] hold_q;
   logic [SLOT_W-1:0]              sel;
   logic                           any;

   // Lowest pending slot wins: slot = 2*lane + chan.
   always_comb begin
      any = |pend_q;
      sel = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (pend_q[s]) sel = SLOT_W'(s);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         hold_q    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_lane  <= '0;
         out_chan  <= 1'b0;
      end else begin
         out_valid <= any;
         if (any) begin
            out_data <= hold_q[sel];
            out_lane <= sel[SLOT_W-1:1];
            out_chan <= sel[0];
         end
         if (load) begin
            pend_q <= load_mask;
            hold_q <= load_data;
         end else if (any) begin
            pend_q[sel] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/audio_lane_capture.sv
module audio_lane_capture #(
   parameter  int LANES    = 4,
   parameter  int SAMPLE_W = 16,
   parameter  int POS_W    = 5,
   parameter  int CNT_W    = 10,
   localparam int LANE_W   = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                samp_en,
   input  logic                frame_start,
   input  logic                ws,
   input  logic [LANES-1:0]    sd,
   input  logic                cfg_lsb_first,
   input  logic [LANE_W-1:0]   cfg_lanes,
   input  logic [POS_W-1:0]    cfg_pos,
   input  logic [1:0]          cfg_mode,
   input  logic                cfg_stereo,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data,
   output logic [LANE_W-1:0]   out_lane,
   output logic                out_chan
);

   import alc_pkg::*;

   localparam int SLOTS = 2 * LANES;

   if ((LANES < 2) || ((LANES & (LANES - 1)) != 0)) begin : g_bad_lanes
      $error("audio_lane_capture: LANES must be a power of two, at least 2");
   end

   logic                           fs, cap_en, cap_chan;
   logic                           started_q;
   logic                           cur_lsb_q, cur_stereo_q;
   logic [LANE_W-1:0]              cur_lanes_q;
   logic [POS_W-1:0]               cur_pos_q;
   cap_mode_e                      cur_mode_q;
   logic                           eff_lsb, eff_stereo;
   logic [POS_W-1:0]               eff_pos;
   logic [LANES-1:0][SAMPLE_W-1:0] left_w, right_w;
   logic [LANES-1:0]               vflag_w;
   logic [SLOTS-1:0]               load_mask;
   logic [SLOTS-1:0][SAMPLE_W-1:0] load_data;

   // The frame-start edge already belongs to the new frame's settings.
   always_comb begin
      eff_lsb    = fs ? cfg_lsb_first : cur_lsb_q;
      eff_stereo = fs ? cfg_stereo    : cur_stereo_q;
      eff_pos    = fs ? cfg_pos       : cur_pos_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q    <= 1'b0;
         cur_lsb_q    <= 1'b0;
         cur_stereo_q <= 1'b0;
         cur_lanes_q  <= '0;
         cur_pos_q    <= '0;
         cur_mode_q   <= CAP_EVERY;
      end else if (fs) begin
         started_q    <= 1'b1;
         cur_lsb_q    <= cfg_lsb_first;
         cur_stereo_q <= cfg_stereo;
         cur_lanes_q  <= cfg_lanes;
         cur_pos_q    <= cfg_pos;
         cur_mode_q   <= cap_mode_e'(cfg_mode);
      end
   end

   alc_frame_track #(
      .SAMPLE_W (SAMPLE_W),
      .POS_W    (POS_W),
      .CNT_W    (CNT_W)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_en     (samp_en),
      .frame_start (frame_start),
      .ws          (ws),
      .pos         (eff_pos),
      .stereo      (eff_stereo),
      .fs          (fs),
      .cap_en      (cap_en),
      .cap_chan    (cap_chan)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      alc_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap_en    (cap_en),
         .cap_chan  (cap_chan),
         .lsb_first (eff_lsb),
         .fs        (fs),
         .sd_bit    (sd[l]),
         .left_q    (left_w[l]),
         .right_q   (right_w[l]),
         .vflag_q   (vflag_w[l])
      );

      // Slot admission uses the finishing frame's latched settings.
      logic lane_ok;
      always_comb begin
         lane_ok = (LANE_W'(l) <= cur_lanes_q) && mode_accepts(cur_mode_q, vflag_w[l]);
         load_mask[2*l]     = lane_ok;
         load_mask[2*l + 1] = lane_ok && cur_stereo_q;
         load_data[2*l]     = left_w[l];
         load_data[2*l + 1] = right_w[l];
      end
   end

   alc_emit #(
      .LANES    (LANES),
      .SAMPLE_W (SAMPLE_W)
   ) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (fs && started_q),
      .load_mask (load_mask),
      .load_data (load_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_lane  (out_lane),
      .out_chan  (out_chan)
   );

endmodule

// File: rtl/alc_capture_chk.sv
module alc_capture_chk #(
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              samp_en,
   input logic              frame_start,
   input logic [LANE_W-1:0] cfg_lanes,
   input logic              cfg_stereo,
   input logic              out_valid,
   input logic [LANE_W-1:0] out_lane,
   input logic              out_chan
);

   localparam int BW = $clog2(2 * LANES + 1) + 1;

   logic              fs;
   logic [1:0]        nfs_q;
   logic [LANE_W-1:0] cur_lanes_q, prev_lanes_q;
   logic              cur_st_q, prev_st_q;
   logic [BW-1:0]     burst_q;

   assign fs = samp_en & frame_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nfs_q        <= '0;
         cur_lanes_q  <= '0;
         prev_lanes_q <= '0;
         cur_st_q     <= 1'b0;
         prev_st_q    <= 1'b0;
         burst_q      <= '0;
      end else begin
         if (fs) begin
            if (nfs_q != 2'd2) nfs_q <= nfs_q + 2'd1;
            cur_lanes_q  <= cfg_lanes;
            prev_lanes_q <= cur_lanes_q;
            cur_st_q     <= cfg_stereo;
            prev_st_q    <= cur_st_q;
            burst_q      <= '0;
         end else if (out_valid && (burst_q != '1)) begin
            burst_q <= burst_q + BW'(1);
         end
      end
   end

   AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1

   AST_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (nfs_q == 2'd2)); // R1

   AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_lane <= prev_lanes_q)); // R5

   AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      burst_q <= BW'(2 * LANES)); // R5

   AST_MONO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !prev_st_q) |-> !out_chan); // R8

   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> ({out_lane, out_chan} > $past({out_lane, out_chan}))); // R9

endmodule

bind audio_lane_capture alc_capture_chk #(
   .LANES  (LANES),
   .LANE_W (LANE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .samp_en     (samp_en),
   .frame_start (frame_start),
   .cfg_lanes   (cfg_lanes),
   .cfg_stereo  (cfg_stereo),
   .out_valid   (out_valid),
   .out_lane    (out_lane),
   .out_chan    (out_chan)
);

// File: tb/audio_lane_capture_tb.sv
`timescale 1ns/1ps
module audio_lane_capture_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        samp_en = 1'b0;
   logic        frame_start = 1'b0;
   logic        ws = 1'b0;
   logic [3:0]  sd = '0;
   logic        cfg_lsb_first = 1'b0;
   logic [1:0]  cfg_lanes = '0;
   logic [4:0]  cfg_pos = '0;
   logic [1:0]  cfg_mode = '0;
   logic        cfg_stereo = 1'b0;
   logic        out_valid;
   logic [15:0] out_data;
   logic [1:0]  out_lane;
   logic        out_chan;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int rec_n = 0;
   logic [15:0] rec_data [16];
   logic [1:0]  rec_lane [16];
   logic        rec_chan [16];
   int          rec_cyc  [16];

   always #4 clk = ~clk;

   audio_lane_capture u_dut (
      .clk (clk), .rst_n (rst_n), .samp_en (samp_en), .frame_start (frame_start),
      .ws (ws), .sd (sd), .cfg_lsb_first (cfg_lsb_first), .cfg_lanes (cfg_lanes),
      .cfg_pos (cfg_pos), .cfg_mode (cfg_mode), .cfg_stereo (cfg_stereo),
      .out_valid (out_valid), .out_data (out_data), .out_lane (out_lane), .out_chan (out_chan)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid && rec_n < 16) begin
         rec_data[rec_n] = out_data;
         rec_lane[rec_n] = out_lane;
         rec_chan[rec_n] = out_chan;
         rec_cyc[rec_n]  = cyc;
         rec_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; samp_en = 1'b0; frame_start = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      rec_n = 0;
   endtask

   function automatic bit accepts(input logic [1:0] m, input logic v);
      if (m == 2'b10) return !v;
      if (m == 2'b11) return v;
      return 1'b1;
   endfunction

   function automatic logic bit_at(input int l, input int h, input int i, input int pos,
                                   input bit lsb, input logic [3:0] vb,
                                   input logic [63:0] lw, input logic [63:0] rw);
      logic [15:0] s;
      int k;
      s = h ? rw[l*16 +: 16] : lw[l*16 +: 16];
      if (i >= pos && i < pos + 16) begin
         k = i - pos;
         return lsb ? s[k] : s[15-k];
      end
      if (h == 0 && i == 0) return vb[l];
      return ((i * 3 + l + h) % 5) == 0;
   endfunction

   // One scenario: reset, configure, one data frame, a closing frame start, compare.
   task automatic run_case(input string req, input logic [1:0] lanes, input bit st, input bit lsb,
                           input int pos, input logic [1:0] mode, input int hl, input bit wsref,
                           input logic [3:0] vb, input bit mid,
                           input logic [63:0] lw, input logic [63:0] rw);
      int c0;
      int e;
      do_reset();
      cfg_lanes = lanes; cfg_stereo = st; cfg_lsb_first = lsb;
      cfg_pos = 5'(pos); cfg_mode = mode;
      for (int h = 0; h < 2; h++) begin
         for (int i = 0; i < hl; i++) begin
            @(negedge clk);
            samp_en = 1'b1;
            frame_start = (h == 0 && i == 0);
            ws = h ? ~wsref : wsref;
            for (int l = 0; l < 4; l++) sd[l] = bit_at(l, h, i, pos, lsb, vb, lw, rw);
            if (mid && h == 0 && i == 2) begin
               cfg_lanes = 2'd0; cfg_stereo = 1'b0; cfg_lsb_first = ~lsb;
               cfg_pos = 5'(pos + 1); cfg_mode = 2'b11;
            end
            @(negedge clk);
            samp_en = 1'b0; frame_start = 1'b0;
            sd = ~sd;
         end
      end
      chk(rec_n == 0, "R1", "words before closing frame", rec_n, 0);
      @(negedge clk);
      samp_en = 1'b1; frame_start = 1'b1; ws = wsref;
      c0 = cyc + 2;
      @(negedge clk);
      samp_en = 1'b0; frame_start = 1'b0;
      repeat (12) @(negedge clk);
      e = 0;
      for (int l = 0; l <= int'(lanes); l++) begin
         for (int c = 0; c <= int'(st); c++) begin
            if (accepts(mode, vb[l])) begin
               if (e < rec_n) begin
                  chk(rec_lane[e] == 2'(l) && rec_chan[e] == 1'(c), req, "lane/chan tag",
                      {rec_lane[e], rec_chan[e]}, l * 2 + c);
                  chk(rec_data[e] == (c ? rw[l*16 +: 16] : lw[l*16 +: 16]), req, "sample word",
                      rec_data[e], c ? rw[l*16 +: 16] : lw[l*16 +: 16]);
                  chk(rec_cyc[e] == c0 + e, "R9", "word cycle", rec_cyc[e], c0 + e);
               end
               e++;
            end
         end
      end
      chk(rec_n == e, req, "word count", rec_n, e);
   endtask

   task automatic t_msb_stereo();   // R2 R4 R5 R8 R9
      run_case("R2", 2'd3, 1'b1, 1'b0, 3, 2'b00, 24, 1'b0, 4'b0000, 1'b0,
               64'h8001_7FFE_C3A5_1234, 64'hF00F_0001_8000_ABCD);
   endtask

   task automatic t_lsb_mono();     // R3 R6 R8
      run_case("R3", 2'd1, 1'b0, 1'b1, 8, 2'b01, 24, 1'b1, 4'b0000, 1'b0,
               64'h0000_0000_8001_5A3C, 64'h0000_0000_FFFF_FFFF);
   endtask

   task automatic t_valid_clear();  // R7: mode 2 keeps lanes 1 and 3
      run_case("R7", 2'd3, 1'b1, 1'b0, 2, 2'b10, 24, 1'b0, 4'b0101, 1'b0,
               64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
   endtask

   task automatic t_valid_set();    // R7: mode 3 keeps lanes 0 and 2
      run_case("R7", 2'd3, 1'b0, 1'b1, 5, 2'b11, 24, 1'b0, 4'b0101, 1'b0,
               64'h9ABC_DEF0_1357_2468, 64'h0);
   endtask

   task automatic t_valid_none();   // R7 R5: lane 3 flag set but inactive
      run_case("R7", 2'd2, 1'b1, 1'b0, 4, 2'b11, 24, 1'b0, 4'b1000, 1'b0,
               64'hAAAA_BBBB_CCCC_DDDD, 64'h1234_5678_9ABC_DEF0);
   endtask

   task automatic t_pos_high();     // R4 R8 R5
      run_case("R4", 2'd0, 1'b1, 1'b0, 31, 2'b00, 48, 1'b1, 4'b0000, 1'b0,
               64'h0000_0000_0000_C0DE, 64'h0000_0000_0000_B00F);
   endtask

   task automatic t_pos_zero();     // R4 R5: first window bit on frame-start edge
      run_case("R5", 2'd2, 1'b1, 1'b1, 0, 2'b00, 20, 1'b0, 4'b0000, 1'b0,
               64'h0000_8421_1248_FFFE, 64'h0000_7BDE_0001_8000);
   endtask

   task automatic t_mid_change();   // R10
      run_case("R10", 2'd3, 1'b1, 1'b0, 4, 2'b00, 24, 1'b0, 4'b0000, 1'b1,
               64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_msb_stereo();
      t_lsb_mono();
      t_valid_clear();
      t_valid_set();
      t_valid_none();
      t_pos_high();
      t_pos_zero();
      t_mid_change();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule